// File: doc/BRIEF.md
# Privilege Mode and Trap Controller

This block keeps the processor's privilege state: one bit that says whether code runs in kernel or user mode, plus a global interrupt-enable flag. It decides when control leaves the running program and where it goes. There are four sources of control transfer:

- synchronous exceptions reported by the pipeline,
- a trap instruction that carries a service number,
- external interrupt lines,
- an internal countdown timer used for time slicing.

On entry the block stores the resume PC and the old status, enters kernel mode and masks interrupts. It then issues a one-cycle redirect to the handler address. That address is read from a 16-entry vector table indexed by the cause number. A return-from-trap request restores the saved state and redirects back to the saved PC.

The kernel uses a small control-operation port to do five things: set or clear the interrupt enable, install vector entries, write the status, and load the timer. All of these are privileged. If user code attempts one, the block raises a privilege-violation exception and the operation has no effect. A return request made in user mode is treated the same way.

Every interface is a plain per-cycle strobe, and there is no back-pressure:
- A request is acted on at the clock edge where it is present, and only that edge.
- The redirect pulse carries no ready, and the fetch stage must follow it.

Top module: `priv_trap_ctrl`

## Requirements
- R1: After reset the block is in kernel mode with interrupts disabled, `redirect_o` low, `next_pc_o`, `epc_o`, `cause_o` and `svc_o` zero, all vector entries zero and the timer idle.
- R2: On taking any entry, after the edge the block shows:
  - `redirect_o` high for exactly one cycle,
  - `next_pc_o` equal to the vector entry selected by `cause_o`,
  - kernel mode with the interrupt enable cleared,
  - `epc_o` equal to the `pc_i` of that cycle,
  - `estatus_o` = {previous kernel bit, previous enable bit}.
- R3: When several sources are present in the same cycle, the order is:
  1. a pipeline exception (`exc_req_i`), which wins;
  2. a privilege violation;
  3. a trap;
  4. interrupts. The timer (cause 0) outranks every external line. Among external lines the lowest index wins, and line k has cause k+1.
- R4: A trap request takes cause 15, is taken regardless of the interrupt enable, and latches `trap_svc_i` into `svc_o`.
- R5: `ctl_op_i` codes are 1 set enable, 2 clear enable, 3 write vector `ctl_idx_i` with `ctl_data_i`, 4 write status (`ctl_data_i[1]` kernel bit, `ctl_data_i[0]` enable bit), and 5 load the timer.
  - In kernel mode these take effect at the edge.
  - In user mode, any of them, and also `rett_i`, raises cause 14 and changes neither the enable, the mode, the vectors nor the timer.
- R6: A return-from-trap in kernel mode restores mode and enable from `estatus_o` and pulses `redirect_o` with `next_pc_o` equal to `epc_o`. If it coincides with an entry, the entry wins. If it coincides with a control operation, the return wins.
- R7: Loading value N>0 into the timer sets a pending time-slice interrupt N edges later. A load of 0 leaves the timer idle. Taking the cause-0 interrupt clears the pending flag, so the interrupt fires once per load.
- R8: Interrupts are taken only at an edge where both `commit_i` and the interrupt enable are high. Exceptions and traps are taken regardless of both.
- R9: A pipeline exception takes the cause number given on `exc_code_i`.
- R10: A vector installed in kernel mode is the handler address used by every later entry with that cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| commit_i | input | 1 | Instruction boundary strobe; interrupts sampled only here |
| pc_i | input | 32 | PC at which the program resumes after a trap |
| irq_i | input | 8 | External interrupt lines, level sensitive |
| trap_req_i | input | 1 | Trap instruction executed this cycle |
| trap_svc_i | input | 8 | Service number carried by the trap |
| exc_req_i | input | 1 | Synchronous exception from the pipeline |
| exc_code_i | input | 4 | Cause number of that exception |
| rett_i | input | 1 | Return-from-trap request |
| ctl_op_i | input | 3 | Privileged control operation code (0 = none) |
| ctl_idx_i | input | 4 | Vector index for a vector write |
| ctl_data_i | input | 32 | Data for vector, status or timer writes |
| redirect_o | output | 1 | One-cycle pulse: fetch must continue at next_pc_o |
| next_pc_o | output | 32 | Redirect target |
| cause_o | output | 4 | Cause of the last entry |
| kmode_o | output | 1 | 1 = kernel mode |
| ie_o | output | 1 | Global interrupt enable |
| epc_o | output | 32 | Saved resume PC |
| estatus_o | output | 2 | Saved {kernel, enable} bits |
| svc_o | output | 8 | Service number of the last trap |

## Verification
Every one of the 256 patterns on the eight external lines is raised in user mode at a commit. This separates the lowest-index choice from any other ordering, and the all-zero pattern confirms that no entry is invented. All 16 exception codes are dispatched and each is returned from. That sweep proves each table entry is addressed separately and that the saved PC and status round-trip. Requests are stacked in the same cycle (exception with trap and interrupt, then trap with interrupt) to pin the ranking. Each privileged operation is attempted from user mode, and a later dispatch or return shows that the operation left no trace. The timer is loaded with a known count and held at commit. This brackets the exact firing edge and shows that the interrupt fires only once.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;

  typedef enum logic [2:0] {
    CTL_NONE    = 3'd0,
    CTL_IE_SET  = 3'd1,
    CTL_IE_CLR  = 3'd2,
    CTL_VEC_WR  = 3'd3,
    CTL_STAT_WR = 3'd4,
    CTL_TMR_LD  = 3'd5
  } ctl_op_e;

  typedef struct packed {
    logic kmode;
    logic ie;
  } stat_t;

  localparam stat_t STAT_BOOT = '{kmode: 1'b1, ie: 1'b0};

endpackage

// File: rtl/trap_vec_table.sv
module trap_vec_table #(
  parameter int VEC_N = 16,
  parameter int XLEN  = 32,
  localparam int IW   = $clog2(VEC_N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IW-1:0]   widx,
  input  logic [XLEN-1:0] wdata,
  input  logic [IW-1:0]   ridx,
  output logic [XLEN-1:0] rdata
);

  logic [XLEN-1:0] entry [VEC_N];

  for (genvar g = 0; g < VEC_N; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        entry[g] <= '0;
      else if (we && widx == IW'(g))
        entry[g] <= wdata;
    end
  end

  assign rdata = entry[ridx];

  assert_install_R10: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> entry[$past(widx)] == $past(wdata));

endmodule

// File: rtl/trap_timer.sv
module trap_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  input  logic             ack,
  output logic             pend
);

  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pend  <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      pend  <= 1'b0;
    end else begin
      if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
      if (cnt_q == TMR_W'(1))
        pend <= 1'b1;
      else if (ack)
        pend <= 1'b0;
    end
  end

  assert_expire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == TMR_W'(1)) |=> pend);

  assert_load_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !pend);

endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter #(
  parameter int NUM_IRQ    = 8,
  parameter int CW         = 4,
  parameter int TRAP_CAUSE = 15,
  parameter int PRIV_CAUSE = 14
) (
  input  logic               exc_req,
  input  logic [CW-1:0]      exc_code,
  input  logic               priv_viol,
  input  logic               trap_req,
  input  logic               int_ok,
  input  logic               tmr_pend,
  input  logic [NUM_IRQ-1:0] irq,
  output logic               take,
  output logic [CW-1:0]      cause,
  output logic               is_trap,
  output logic               tmr_ack
);

  logic [NUM_IRQ-1:0] first;
  logic [CW-1:0]      irq_cause;

  assign first[0] = irq[0];
  for (genvar k = 1; k < NUM_IRQ; k++) begin : g_first
    assign first[k] = irq[k] & ~(|irq[k-1:0]);
  end

  always_comb begin
    irq_cause = '0;
    for (int k = 0; k < NUM_IRQ; k++)
      if (first[k]) irq_cause = irq_cause | CW'(k + 1);
  end

  always_comb begin
    take    = 1'b1;
    cause   = '0;
    is_trap = 1'b0;
    tmr_ack = 1'b0;
    if (exc_req)
      cause = exc_code;
    else if (priv_viol)
      cause = CW'(PRIV_CAUSE);
    else if (trap_req) begin
      cause   = CW'(TRAP_CAUSE);
      is_trap = 1'b1;
    end else if (int_ok && tmr_pend) begin
      cause   = '0;
      tmr_ack = 1'b1;
    end else if (int_ok && |irq)
      cause = irq_cause;
    else
      take = 1'b0;
  end

endmodule

// File: rtl/priv_trap_ctrl.sv
module priv_trap_ctrl #(
  parameter int XLEN    = 32,
  parameter int NUM_IRQ = 8,
  parameter int VEC_N   = 16,
  parameter int TMR_W   = 16,
  parameter int SVC_W   = 8,
  localparam int CW     = $clog2(VEC_N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               trap_req_i,
  input  logic [SVC_W-1:0]   trap_svc_i,
  input  logic               exc_req_i,
  input  logic [CW-1:0]      exc_code_i,
  input  logic               rett_i,
  input  logic [2:0]         ctl_op_i,
  input  logic [CW-1:0]      ctl_idx_i,
  input  logic [XLEN-1:0]    ctl_data_i,
  output logic               redirect_o,
  output logic [XLEN-1:0]    next_pc_o,
  output logic [CW-1:0]      cause_o,
  output logic               kmode_o,
  output logic               ie_o,
  output logic [XLEN-1:0]    epc_o,
  output logic [1:0]         estatus_o,
  output logic [SVC_W-1:0]   svc_o
);
  import priv_trap_pkg::*;

  localparam int TRAP_CAUSE = VEC_N - 1;
  localparam int PRIV_CAUSE = VEC_N - 2;

  stat_t            st_q, est_q;
  logic [XLEN-1:0]  epc_q, npc_q;
  logic [CW-1:0]    cause_q;
  logic [SVC_W-1:0] svc_q;
  logic             redir_q;

  ctl_op_e          op;
  logic             op_valid, priv_viol, take, is_trap, tmr_ack, tmr_pend;
  logic             do_ctl, rett_go;
  logic [CW-1:0]    cause_d;
  logic [XLEN-1:0]  vec_rdata;

  always_comb begin
    op       = CTL_NONE;
    op_valid = 1'b1;
    case (ctl_op_i)
      3'd1:    op = CTL_IE_SET;
      3'd2:    op = CTL_IE_CLR;
      3'd3:    op = CTL_VEC_WR;
      3'd4:    op = CTL_STAT_WR;
      3'd5:    op = CTL_TMR_LD;
      default: op_valid = 1'b0;
    endcase
  end

  assign priv_viol = !st_q.kmode && (op_valid || rett_i);
  assign do_ctl    = st_q.kmode && !take && !rett_i && op_valid;
  assign rett_go   = st_q.kmode && !take && rett_i;

  trap_arbiter #(
    .NUM_IRQ(NUM_IRQ), .CW(CW), .TRAP_CAUSE(TRAP_CAUSE), .PRIV_CAUSE(PRIV_CAUSE)
  ) u_arb (
    .exc_req  (exc_req_i),
    .exc_code (exc_code_i),
    .priv_viol(priv_viol),
    .trap_req (trap_req_i),
    .int_ok   (commit_i && st_q.ie),
    .tmr_pend (tmr_pend),
    .irq      (irq_i),
    .take     (take),
    .cause    (cause_d),
    .is_trap  (is_trap),
    .tmr_ack  (tmr_ack)
  );

  trap_vec_table #(.VEC_N(VEC_N), .XLEN(XLEN)) u_vec (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (do_ctl && op == CTL_VEC_WR),
    .widx (ctl_idx_i),
    .wdata(ctl_data_i),
    .ridx (cause_d),
    .rdata(vec_rdata)
  );

  trap_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (do_ctl && op == CTL_TMR_LD),
    .load_val(ctl_data_i[TMR_W-1:0]),
    .ack     (take && tmr_ack),
    .pend    (tmr_pend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= STAT_BOOT;
      est_q   <= '0;
      epc_q   <= '0;
      npc_q   <= '0;
      cause_q <= '0;
      svc_q   <= '0;
      redir_q <= 1'b0;
    end else begin
      redir_q <= 1'b0;
      if (take) begin
        est_q   <= st_q;
        epc_q   <= pc_i;
        st_q    <= STAT_BOOT;
        cause_q <= cause_d;
        npc_q   <= vec_rdata;
        redir_q <= 1'b1;
        if (is_trap) svc_q <= trap_svc_i;
      end else if (rett_go) begin
        st_q    <= est_q;
        npc_q   <= epc_q;
        redir_q <= 1'b1;
      end else if (do_ctl) begin
        case (op)
          CTL_IE_SET:  st_q.ie <= 1'b1;
          CTL_IE_CLR:  st_q.ie <= 1'b0;
          CTL_STAT_WR: st_q    <= '{kmode: ctl_data_i[1], ie: ctl_data_i[0]};
          default:     ;
        endcase
      end
    end
  end

  assign redirect_o = redir_q;
  assign next_pc_o  = npc_q;
  assign cause_o    = cause_q;
  assign kmode_o    = st_q.kmode;
  assign ie_o       = st_q.ie;
  assign epc_o      = epc_q;
  assign estatus_o  = est_q;
  assign svc_o      = svc_q;

  assert_entry_kernel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> kmode_o && !ie_o && redirect_o);

  assert_epc_saved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> epc_o == $past(pc_i) && estatus_o == $past({kmode_o, ie_o}));

  assert_exc_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_i |=> redirect_o && cause_o == $past(exc_code_i));

  assert_trap_svc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req_i && !exc_req_i && !priv_viol) |=>
      svc_o == $past(trap_svc_i) && cause_o == CW'(TRAP_CAUSE));

  assert_user_ctl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!kmode_o && op_valid && !exc_req_i) |=>
      redirect_o && kmode_o && cause_o == CW'(PRIV_CAUSE));

  assert_rett_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rett_go |=> {kmode_o, ie_o} == $past(estatus_o) && next_pc_o == $past(epc_o)
                && redirect_o);

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req_i && !trap_req_i && ctl_op_i == 3'd0 && !rett_i && !commit_i)
      |=> !redirect_o);

endmodule

// File: tb/priv_trap_ctrl_tb.sv
`timescale 1ns/1ps
module priv_trap_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        commit = 1'b0;
  logic [31:0] pc = '0;
  logic [7:0]  irq = '0;
  logic        trap_req = 1'b0;
  logic [7:0]  trap_svc = '0;
  logic        exc_req = 1'b0;
  logic [3:0]  exc_code = '0;
  logic        rett = 1'b0;
  logic [2:0]  ctl_op = '0;
  logic [3:0]  ctl_idx = '0;
  logic [31:0] ctl_data = '0;

  logic        redirect, kmode, ie;
  logic [31:0] next_pc, epc;
  logic [3:0]  cause;
  logic [1:0]  estatus;
  logic [7:0]  svc;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  priv_trap_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .commit_i(commit), .pc_i(pc), .irq_i(irq),
    .trap_req_i(trap_req), .trap_svc_i(trap_svc), .exc_req_i(exc_req),
    .exc_code_i(exc_code), .rett_i(rett), .ctl_op_i(ctl_op), .ctl_idx_i(ctl_idx),
    .ctl_data_i(ctl_data), .redirect_o(redirect), .next_pc_o(next_pc),
    .cause_o(cause), .kmode_o(kmode), .ie_o(ie), .epc_o(epc),
    .estatus_o(estatus), .svc_o(svc)
  );

  function automatic logic [31:0] vec_of(int i);
    return 32'h0001_0000 + 32'(i) * 32'h100;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ctl(input logic [2:0] op, input logic [3:0] idx, input logic [31:0] d);
    ctl_op = op; ctl_idx = idx; ctl_data = d;
    cyc();
    ctl_op = '0; ctl_idx = '0; ctl_data = '0;
  endtask

  task automatic do_rett();
    rett = 1'b1;
    cyc();
    rett = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, before any post-reset edge
    eq("R1 kmode", 32'(kmode), 1);
    eq("R1 ie", 32'(ie), 0);
    eq("R1 redirect", 32'(redirect), 0);
    eq("R1 next_pc", next_pc, 0);
    eq("R1 epc", epc, 0);
    eq("R1 svc", 32'(svc), 0);

    // R1: a trap taken before any vector is installed dispatches to zero
    trap_req = 1'b1; cyc(); trap_req = 1'b0;
    eq("R1 vector zero", next_pc, 0);
    do_rett();   // returns to kernel, ie=0

    // R10: install every vector
    for (int i = 0; i < 16; i++) ctl(3'd5 - 3'd2, 4'(i), vec_of(i));
    // R5: status write in kernel -> user mode, ie set
    ctl(3'd4, 4'd0, 32'h1);
    eq("R5 status write mode", 32'(kmode), 0);
    eq("R5 status write ie", 32'(ie), 1);

    // R9 R2 R6 R10: every exception code
    for (int c = 0; c < 16; c++) begin
      exc_req = 1'b1; exc_code = 4'(c); pc = 32'h4000 + 32'(c) * 4;
      cyc();
      exc_req = 1'b0;
      eq("R2 redirect", 32'(redirect), 1);
      eq("R10 next_pc", next_pc, vec_of(c));
      eq("R9 cause", 32'(cause), c);
      eq("R2 kernel", 32'(kmode), 1);
      eq("R2 ie cleared", 32'(ie), 0);
      eq("R2 epc", epc, 32'h4000 + 32'(c) * 4);
      eq("R2 estatus", 32'(estatus), 1);
      do_rett();
      eq("R6 redirect", 32'(redirect), 1);
      eq("R6 pc", next_pc, 32'h4000 + 32'(c) * 4);
      eq("R6 mode", 32'(kmode), 0);
      eq("R6 ie", 32'(ie), 1);
      cyc();
      eq("R2 pulse one cycle", 32'(redirect), 0);
    end

    // R4: trap
    trap_req = 1'b1; trap_svc = 8'hA5; pc = 32'h5000;
    cyc();
    trap_req = 1'b0; trap_svc = '0;
    eq("R4 cause", 32'(cause), 15);
    eq("R4 svc", 32'(svc), 32'hA5);
    eq("R4 next_pc", next_pc, vec_of(15));
    eq("R4 estatus", 32'(estatus), 1);
    do_rett();

    // R3: exception beats trap and interrupt
    exc_req = 1'b1; exc_code = 4'd3; trap_req = 1'b1; irq = 8'h01; commit = 1'b1;
    cyc();
    exc_req = 1'b0; trap_req = 1'b0; irq = '0; commit = 1'b0;
    eq("R3 exc wins", 32'(cause), 3);
    do_rett();
    // R3: trap beats interrupt
    trap_req = 1'b1; irq = 8'h01; commit = 1'b1;
    cyc();
    trap_req = 1'b0; irq = '0; commit = 1'b0;
    eq("R3 trap wins", 32'(cause), 15);
    do_rett();

    // R3 R8: every irq pattern
    for (int p = 0; p < 256; p++) begin
      int lo;
      lo = 0;
      for (int b = 7; b >= 0; b--) if (p[b]) lo = b + 1;
      irq = 8'(p); commit = 1'b1;
      cyc();
      irq = '0; commit = 1'b0;
      if (p == 0) begin
        eq("R3 no source no entry", 32'(redirect), 0);
        eq("R3 stays user", 32'(kmode), 0);
      end else begin
        eq("R3 lowest line", 32'(cause), lo);
        eq("R3 irq vector", next_pc, vec_of(lo));
        do_rett();
      end
    end

    // R8: no commit, no interrupt
    irq = 8'h10; commit = 1'b0;
    cyc();
    irq = '0;
    eq("R8 commit gate", 32'(redirect), 0);
    eq("R8 commit gate mode", 32'(kmode), 0);

    // R5: clear enable from user mode
    ctl(3'd2, 4'd0, 32'h0);
    eq("R5 ie_clr cause", 32'(cause), 14);
    eq("R5 ie_clr estatus", 32'(estatus), 1);
    do_rett();
    eq("R5 ie unchanged", 32'(ie), 1);
    // R5: vector write from user mode
    ctl(3'd3, 4'd5, 32'hDEAD_0000);
    eq("R5 vec_wr cause", 32'(cause), 14);
    do_rett();
    exc_req = 1'b1; exc_code = 4'd5;
    cyc();
    exc_req = 1'b0;
    eq("R5 vector unchanged", next_pc, vec_of(5));
    do_rett();
    // R5: status write from user mode
    ctl(3'd4, 4'd0, 32'h2);
    eq("R5 stat_wr cause", 32'(cause), 14);
    do_rett();
    eq("R5 mode unchanged", 32'(kmode), 0);
    // R5: timer load from user mode has no effect
    ctl(3'd5, 4'd0, 32'd2);
    eq("R5 tmr_ld cause", 32'(cause), 14);
    do_rett();
    commit = 1'b1;
    for (int k = 0; k < 6; k++) begin
      cyc();
      eq("R5 timer not loaded", 32'(redirect), 0);
    end
    commit = 1'b0;
    // R5: return from user mode
    do_rett();
    eq("R5 rett in user cause", 32'(cause), 14);
    eq("R5 rett in user mode", 32'(kmode), 1);

    // R7: timer, loaded in kernel
    ctl(3'd5, 4'd0, 32'd5);
    ctl(3'd4, 4'd0, 32'h1);
    commit = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      cyc();
      if (k < 5) eq("R7 not yet", 32'(redirect), 0);
      else begin
        eq("R7 fires", 32'(redirect), 1);
        eq("R7 cause", 32'(cause), 0);
        eq("R7 vector", next_pc, vec_of(0));
      end
    end
    commit = 1'b0;
    do_rett();
    commit = 1'b1;
    for (int k = 0; k < 8; k++) begin
      cyc();
      eq("R7 fires once", 32'(redirect), 0);
    end
    commit = 1'b0;

    // R8: interrupts masked when ie=0, exceptions still taken
    trap_req = 1'b1; cyc(); trap_req = 1'b0;
    ctl(3'd4, 4'd0, 32'h0);
    irq = 8'h01; commit = 1'b1;
    cyc();
    irq = '0; commit = 1'b0;
    eq("R8 ie gate", 32'(redirect), 0);
    exc_req = 1'b1; exc_code = 4'd2;
    cyc();
    exc_req = 1'b0;
    eq("R8 exc with ie=0", 32'(redirect), 1);
    eq("R8 exc cause", 32'(cause), 2);

    finish_up();
  end

endmodule